// File: doc/BRIEF.md
# Sparse Fiber Format Encoder

This block takes one dense fiber of up to `FIBER_LEN` values, which arrive one per cycle on a valid/ready stream closed by a last marker. It re-emits the fiber in compressed form. The payload stream carries only the elements that must be stored. The metadata stream carries location information in one of four encodings, chosen per fiber:
- an occupancy bitmask,
- explicit coordinates,
- zero-run tags,
- a running-offset list.

When a fiber has been fully encoded, a one-cycle strobe reports how many nonzero values it held.

A producer of sparse tensor tiles places it between a dense source and a storage writer. The same hardware then serves whichever format suits a rank. Bitmask and offset metadata grow with the fiber length. Coordinate and zero-run metadata grow with the number of nonzeros. Both output streams are registered. A stall on either output stops input acceptance.

Top module: `sparse_fiber_encoder`

## Requirements
- R1: The payload stream carries every nonzero input value exactly once, in arrival (coordinate) order. The only zero it ever carries is the saturation element of R5.
- R2: Format code 0 (bitmask) emits exactly one metadata word, when the last element is accepted. Bit i of that word is 1 when position i was nonzero, and bits at or beyond the fiber length are 0. The fiber [0,0,c,d,0,f] gives 0x002C.
- R3: Format code 1 (coordinate) emits one metadata word per nonzero, equal to its position. The example fiber gives 2,3,5.
- R4: Format code 2 (zero-run) emits, with each payload, the number of zeros accepted since the previous payload or since the fiber start. The example fiber gives 2,0,1.
- R5: In zero-run mode, a zero that arrives while the run count equals 2^FIELD_W-1 is emitted as a payload of value 0 tagged with 2^FIELD_W-1, and the run count restarts at 0.
- R6: Format code 3 (offset) emits length+1 metadata words: for each position, the number of nonzeros before it, then the total. The example fiber gives 0,0,0,1,2,2,3.
- R7: The format select is sampled with the first element of a fiber. Changing it during the fiber has no effect on that fiber's output.
- R8: A valid output holds its data until accepted. in_ready is low whenever an output slot is full and its ready is low, and while the offset total is waiting.
- R9: After each fiber, done is high for exactly one cycle, and occ_count then equals that fiber's nonzero count. Saturation zeros are not counted.
- R10: After reset, pay_valid, meta_valid and done are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Metadata format code: 0 bitmask, 1 coordinate, 2 zero-run, 3 offset |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted when high with in_valid |
| in_data | input | VAL_W | Dense element value |
| in_last | input | 1 | Marks the final element of the fiber |
| pay_valid | output | 1 | Payload word valid |
| pay_ready | input | 1 | Payload consumer ready |
| pay_data | output | VAL_W | Payload value |
| meta_valid | output | 1 | Metadata word valid |
| meta_ready | input | 1 | Metadata consumer ready |
| meta_data | output | META_W | Metadata word (mask, coordinate, run or offset) |
| done | output | 1 | One-cycle end-of-fiber strobe |
| occ_count | output | CNT_W | Nonzero count of the last finished fiber |

## Verification
Some internal faults show on the metadata stream within one element:
- a slipped position counter shifts every coordinate that follows;
- a stuck run counter corrupts the next zero-run tag;
- a wrong nonzero count corrupts the next offset.

A bitmask fault stays hidden until the single word at the end of the fiber, and a fault in the occupancy register shows only at the done strobe. A fault in slot ordering under backpressure shows as lost or duplicated words once a stalled output is released. The directed fibers are therefore repeated with both ready inputs toggling.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    typedef enum logic [1:0] {
        FMT_MASK  = 2'd0,
        FMT_COORD = 2'd1,
        FMT_RUN   = 2'd2,
        FMT_OFFS  = 2'd3
    } fmt_e;
endpackage

// File: rtl/sfe_out_slot.sv
module sfe_out_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         free
);
    typedef struct packed {
        logic         v;
        logic [W-1:0] d;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.v && ready) st_d.v = 1'b0;
        if (load) begin
            st_d.v = 1'b1;
            st_d.d = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.v;
    assign data  = st_q.d;
    assign free  = !st_q.v || ready;

    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data)));
endmodule

// File: rtl/sfe_elem_gen.sv
module sfe_elem_gen
    import sfe_pkg::*;
#(
    parameter int FIBER_LEN = 16,
    parameter int VAL_W     = 8,
    parameter int FIELD_W   = 4,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 5,
    parameter int META_W    = 16
) (
    input  fmt_e                 fmt,
    input  logic [VAL_W-1:0]     data,
    input  logic                 last,
    input  logic [IDX_W-1:0]     pos,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [FIELD_W-1:0]   run,
    input  logic [FIBER_LEN-1:0] mask,
    output logic                 nz,
    output logic                 pay_load,
    output logic [VAL_W-1:0]     pay_word,
    output logic                 meta_load,
    output logic [META_W-1:0]    meta_word,
    output logic [FIELD_W-1:0]   run_next,
    output logic [FIBER_LEN-1:0] mask_next
);
    localparam logic [FIELD_W-1:0] RUN_MAX = '1;

    always_comb begin
        nz        = |data;
        pay_load  = nz;
        pay_word  = data;
        meta_load = 1'b0;
        meta_word = '0;
        run_next  = run;
        mask_next = mask;
        case (fmt)
            FMT_MASK: begin
                if (nz) mask_next = mask | ({{(FIBER_LEN-1){1'b0}}, 1'b1} << pos);
                meta_load = last;
                meta_word = META_W'(mask_next);
            end
            FMT_COORD: begin
                meta_load = nz;
                meta_word = META_W'(pos);
            end
            FMT_RUN: begin
                if (nz) begin
                    meta_load = 1'b1;
                    meta_word = META_W'(run);
                    run_next  = '0;
                end else if (run == RUN_MAX) begin
                    pay_load  = 1'b1;
                    pay_word  = '0;
                    meta_load = 1'b1;
                    meta_word = META_W'(RUN_MAX);
                    run_next  = '0;
                end else begin
                    run_next = run + 1'b1;
                end
            end
            default: begin
                meta_load = 1'b1;
                meta_word = META_W'(cnt);
            end
        endcase
    end
endmodule

// File: rtl/sparse_fiber_encoder.sv
module sparse_fiber_encoder
    import sfe_pkg::*;
#(
    parameter int  FIBER_LEN = 16,
    parameter int  VAL_W     = 8,
    parameter int  FIELD_W   = 4,
    localparam int CNT_W     = $clog2(FIBER_LEN + 1),
    localparam int META_W    = (FIBER_LEN > FIELD_W) ? FIBER_LEN : FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VAL_W-1:0]  in_data,
    input  logic              in_last,
    output logic              pay_valid,
    input  logic              pay_ready,
    output logic [VAL_W-1:0]  pay_data,
    output logic              meta_valid,
    input  logic              meta_ready,
    output logic [META_W-1:0] meta_data,
    output logic              done,
    output logic [CNT_W-1:0]  occ_count
);
    localparam int IDX_W = (FIBER_LEN > 1) ? $clog2(FIBER_LEN) : 1;

    typedef struct packed {
        logic [IDX_W-1:0]     pos;
        logic [CNT_W-1:0]     cnt;
        logic [FIELD_W-1:0]   run;
        logic [FIBER_LEN-1:0] mask;
        fmt_e                 fmt;
        logic                 pend;
        logic                 done;
        logic [CNT_W-1:0]     occ;
    } enc_t;

    enc_t st_d, st_q;

    logic                 pay_free, meta_free, fire;
    fmt_e                 fmt_eff;
    logic                 g_nz, g_pay_load, g_meta_load;
    logic [VAL_W-1:0]     g_pay_word;
    logic [META_W-1:0]    g_meta_word;
    logic [FIELD_W-1:0]   g_run_next;
    logic [FIBER_LEN-1:0] g_mask_next;
    logic                 pay_ld, meta_ld;
    logic [META_W-1:0]    meta_in;
    logic [CNT_W-1:0]     cnt_inc;

    assign in_ready = pay_free && meta_free && !st_q.pend;
    assign fire     = in_valid && in_ready;
    assign fmt_eff  = (st_q.pos == '0) ? fmt_e'(fmt_sel) : st_q.fmt;
    assign cnt_inc  = st_q.cnt + CNT_W'(g_nz);

    sfe_elem_gen #(
        .FIBER_LEN(FIBER_LEN), .VAL_W(VAL_W), .FIELD_W(FIELD_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .META_W(META_W)
    ) u_gen (
        .fmt(fmt_eff), .data(in_data), .last(in_last),
        .pos(st_q.pos), .cnt(st_q.cnt), .run(st_q.run), .mask(st_q.mask),
        .nz(g_nz), .pay_load(g_pay_load), .pay_word(g_pay_word),
        .meta_load(g_meta_load), .meta_word(g_meta_word),
        .run_next(g_run_next), .mask_next(g_mask_next)
    );

    assign pay_ld  = fire && g_pay_load;
    assign meta_ld = (fire && g_meta_load) || (st_q.pend && meta_free);
    assign meta_in = st_q.pend ? META_W'(st_q.occ) : g_meta_word;

    sfe_out_slot #(.W(VAL_W)) u_pay (
        .clk(clk), .rst_n(rst_n), .load(pay_ld), .load_data(g_pay_word),
        .ready(pay_ready), .valid(pay_valid), .data(pay_data), .free(pay_free)
    );

    sfe_out_slot #(.W(META_W)) u_meta (
        .clk(clk), .rst_n(rst_n), .load(meta_ld), .load_data(meta_in),
        .ready(meta_ready), .valid(meta_valid), .data(meta_data), .free(meta_free)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.pend && meta_free) begin
            st_d.pend = 1'b0;
            st_d.done = 1'b1;
        end
        if (fire) begin
            st_d.fmt = fmt_eff;
            if (in_last) begin
                st_d.occ  = cnt_inc;
                st_d.pos  = '0;
                st_d.cnt  = '0;
                st_d.run  = '0;
                st_d.mask = '0;
                if (fmt_eff == FMT_OFFS) st_d.pend = 1'b1;
                else                     st_d.done = 1'b1;
            end else begin
                st_d.pos  = st_q.pos + 1'b1;
                st_d.cnt  = cnt_inc;
                st_d.run  = g_run_next;
                st_d.mask = g_mask_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign occ_count = st_q.occ;

    // R8
    stall_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && !pay_ready) |-> !in_ready);
    // R8
    stall_meta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_valid && !meta_ready) |-> !in_ready);
    // R9
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (occ_count <= CNT_W'(FIBER_LEN)));
    // R1
    zero_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && pay_data == '0) |-> (st_q.fmt == FMT_RUN));
endmodule

// File: tb/sim_sparse_fiber_encoder.sv
module sim_sparse_fiber_encoder;
    localparam int N    = 16;
    localparam int VW   = 8;
    localparam int FW   = 4;
    localparam int CW   = $clog2(N + 1);
    localparam int MW   = 16;
    localparam int RMAX = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    fmt_sel = 2'd0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          pay_valid;
    logic          pay_ready = 1'b1;
    logic [VW-1:0] pay_data;
    logic          meta_valid;
    logic          meta_ready = 1'b1;
    logic [MW-1:0] meta_data;
    logic          done;
    logic [CW-1:0] occ_count;

    int checks = 0;
    int failures = 0;
    int got_pay[$];
    int got_meta[$];
    int exp_pay[$];
    int exp_meta[$];
    int done_cnt = 0;
    int occ_seen = 0;
    int cyc = 0;
    bit bp_mode = 1'b0;
    bit hold_meta = 1'b0;
    logic [VW-1:0] fib [0:N-1];
    int flen = 0;

    always #4 clk = ~clk;

    sparse_fiber_encoder #(.FIBER_LEN(N), .VAL_W(VW), .FIELD_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .meta_valid(meta_valid), .meta_ready(meta_ready), .meta_data(meta_data),
        .done(done), .occ_count(occ_count)
    );

    always @(posedge clk) begin
        #1;
        cyc++;
        pay_ready  = bp_mode ? ((cyc % 3) != 0) : 1'b1;
        meta_ready = hold_meta ? 1'b0 : (bp_mode ? ((cyc % 2) == 0) : 1'b1);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (pay_valid && pay_ready)   got_pay.push_back(int'(pay_data));
            if (meta_valid && meta_ready) got_meta.push_back(int'(meta_data));
            if (done) begin
                done_cnt++;
                occ_seen = int'(occ_count);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_expect(input int fmt, output int occ);
        int run = 0;
        int nzc = 0;
        int msk = 0;
        exp_pay.delete();
        exp_meta.delete();
        for (int i = 0; i < flen; i++) begin
            if (fib[i] != 0) begin
                exp_pay.push_back(int'(fib[i]));
                msk |= (1 << i);
                if (fmt == 1) exp_meta.push_back(i);
                if (fmt == 2) begin exp_meta.push_back(run); run = 0; end
            end else if (fmt == 2) begin
                if (run == RMAX) begin
                    exp_pay.push_back(0);
                    exp_meta.push_back(RMAX);
                    run = 0;
                end else run++;
            end
            if (fmt == 3) exp_meta.push_back(nzc);
            if (fib[i] != 0) nzc++;
        end
        if (fmt == 0) exp_meta.push_back(msk);
        if (fmt == 3) exp_meta.push_back(nzc);
        occ = nzc;
    endtask

    task automatic drive_fiber(input int fmt, input bit swap_fmt);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fib[i];
            in_last  = (i == flen - 1);
            fmt_sel  = (swap_fmt && i > 0) ? 2'(fmt ^ 1) : 2'(fmt);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 300; k++) begin
            if (done_cnt > 0 && !pay_valid && !meta_valid && k > 3) break;
            @(negedge clk);
        end
    endtask

    task automatic run_fiber(input int fmt, input bit swap_fmt, input string req);
        int occ;
        got_pay.delete();
        got_meta.delete();
        done_cnt = 0;
        build_expect(fmt, occ);
        drive_fiber(fmt, swap_fmt);
        wait_drain();
        chk(got_pay.size() == exp_pay.size(), {req, " R1 payload count"}, got_pay.size(), exp_pay.size());
        for (int i = 0; i < exp_pay.size() && i < got_pay.size(); i++)
            chk(got_pay[i] == exp_pay[i], {req, " R1 payload value"}, got_pay[i], exp_pay[i]);
        chk(got_meta.size() == exp_meta.size(), {req, " metadata count"}, got_meta.size(), exp_meta.size());
        for (int i = 0; i < exp_meta.size() && i < got_meta.size(); i++)
            chk(got_meta[i] == exp_meta[i], {req, " metadata value"}, got_meta[i], exp_meta[i]);
        chk(done_cnt == 1, {req, " R9 done pulses"}, done_cnt, 1);
        chk(occ_seen == occ, {req, " R9 occupancy"}, occ_seen, occ);
    endtask

    task automatic load_example();
        flen = 6;
        fib[0] = 8'h00; fib[1] = 8'h00; fib[2] = 8'h0C;
        fib[3] = 8'h0D; fib[4] = 8'h00; fib[5] = 8'h0F;
    endtask

    task automatic t_reset();
        chk(pay_valid == 1'b0, "R10 pay_valid", pay_valid, 0);
        chk(meta_valid == 1'b0, "R10 meta_valid", meta_valid, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    endtask

    task automatic t_example_all();
        load_example();
        run_fiber(0, 1'b0, "R2 bitmask");
        chk(got_meta.size() > 0 && got_meta[0] == 'h2C, "R2 mask word", got_meta.size() > 0 ? got_meta[0] : -1, 'h2C);
        run_fiber(1, 1'b0, "R3 coord");
        run_fiber(2, 1'b0, "R4 run");
        run_fiber(3, 1'b0, "R6 offset");
        chk(got_meta.size() == 7, "R6 entry count", got_meta.size(), 7);
    endtask

    task automatic t_saturation();
        flen = 16;
        for (int i = 0; i < 16; i++) fib[i] = 8'h00;
        run_fiber(2, 1'b0, "R5 all zero");
        for (int i = 0; i < 15; i++) fib[i] = 8'h00;
        fib[15] = 8'h33;
        run_fiber(2, 1'b0, "R5 max run no force");
        for (int i = 0; i < 16; i++) fib[i] = (i % 5 == 4) ? 8'h00 : 8'(i + 1);
        run_fiber(2, 1'b0, "R4 mixed");
        run_fiber(0, 1'b0, "R2 full length");
    endtask

    task automatic t_fmt_latch();
        load_example();
        run_fiber(1, 1'b1, "R7 coord with select swapped");
        run_fiber(2, 1'b1, "R7 run with select swapped");
    endtask

    task automatic t_backpressure();
        bp_mode = 1'b1;
        load_example();
        run_fiber(1, 1'b0, "R8 coord under stall");
        run_fiber(3, 1'b0, "R8 offset under stall");
        flen = 16;
        for (int i = 0; i < 16; i++) fib[i] = 8'(8'hA0 + i);
        run_fiber(0, 1'b0, "R8 dense mask under stall");
        bp_mode = 1'b0;
    endtask

    task automatic t_hold();
        got_pay.delete();
        got_meta.delete();
        done_cnt = 0;
        hold_meta = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h55; in_last = 1'b1; fmt_sel = 2'd1;
        #1;
        chk(in_ready == 1'b1, "R8 ready before stall", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(meta_valid == 1'b1, "R8 meta held valid", meta_valid, 1);
            chk(meta_data == '0, "R8 meta held data", int'(meta_data), 0);
            chk(in_ready == 1'b0, "R8 in_ready low on stall", in_ready, 0);
            @(negedge clk);
        end
        hold_meta = 1'b0;
        wait_drain();
        chk(got_meta.size() == 1, "R8 meta count after release", got_meta.size(), 1);
        chk(got_pay.size() == 1 && got_pay[0] == 'h55, "R1 single payload", got_pay.size(), 1);
        chk(occ_seen == 1, "R9 single occupancy", occ_seen, 1);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example_all();
        t_saturation();
        t_fmt_latch();
        t_backpressure();
        t_hold();
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule